// File: doc/BRIEF.md
# Photon Absorption Scoring Unit

This block performs the absorption step for photon packets that stream through a fixed-point Monte Carlo light-transport pipeline. Each packet brings its weight, its radial and depth position, and the index of the tissue layer it is in. The block takes away the share of weight that the layer absorbs and passes the reduced weight on one cycle later. It adds the removed share into an on-chip grid of absorption totals, indexed by radial bin and depth bin. Reflectance and transmittance are not tracked.

A packet can arrive on every cycle. Two updates to the same cell that are close together in time are merged through a bypass path, so the read-modify-write of the grid loses no weight. Before a run, the grid is cleared by a sweep over all cells. Software loads one absorbed-fraction constant per layer, computed ahead of time as the layer's absorption coefficient over its total attenuation. Voxel edges are powers of two, and the shift for each axis is a run-time input. After the run, the totals are read out one cell at a time through an address/data port.

Top module: `absorb_score`

## Requirements
- R1: The weight out is `W - floor(W*F/65536)`, where W is the packet weight and F is the 16-bit fraction loaded for the packet's layer. It appears on `pkt_weight_o`, with `pkt_valid_o` high, in the cycle after the packet is sampled.
- R2: A layer whose fraction is zero passes the weight through unchanged and leaves its grid cell unchanged.
- R3: Each of the five layers keeps its own fraction. A layer index of 5 or more uses the fraction of layer 4.
- R4: The radial bin is `r >> dr_shift_i` and the depth bin is `z >> dz_shift_i`. Cell (rb, zb) is read back by presenting rb and zb on the readout port.
- R5: A bin index above the last bin, 31 for the default 32x32 grid, is clamped to the last bin. A bin index equal to the last bin is not changed.
- R6: Each cell accumulates the absorbed amounts of all packets that map to it, in 32 bits. A cell that would pass 0xFFFFFFFF saturates at 0xFFFFFFFF.
- R7: Packets that hit the same cell on consecutive cycles, or on alternate cycles, all add their amounts. No update is lost.
- R8: When `rd_en_i` is high and no packet is in the first stage, the cell contents appear on `rd_data_o` with `rd_valid_o` high one cycle later. When a packet is in the first stage, `rd_valid_o` stays low.
- R9: A pulse on `clr_i` zeros every cell. `busy_o` stays high for exactly R_BINS*Z_BINS cycles. While `busy_o` is high, packets are dropped: `pkt_valid_o` does not rise and no cell changes.
- R10: During and directly after reset, `pkt_valid_o`, `rd_valid_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write enable for a layer fraction |
| cfg_layer_i | input | 3 | Layer index for the fraction write |
| cfg_ratio_i | input | 16 | Absorbed fraction, unsigned Q0.16 |
| dr_shift_i | input | 5 | Radial voxel size as log2 |
| dz_shift_i | input | 5 | Depth voxel size as log2 |
| pkt_valid_i | input | 1 | Packet present |
| pkt_weight_i | input | 32 | Packet weight |
| pkt_layer_i | input | 3 | Layer at the interaction site |
| pkt_r_i | input | 16 | Radial position |
| pkt_z_i | input | 16 | Depth position |
| pkt_valid_o | output | 1 | Packet leaving the block |
| pkt_weight_o | output | 32 | Weight after absorption |
| clr_i | input | 1 | Start a grid clear |
| busy_o | output | 1 | Clear sweep in progress |
| rd_en_i | input | 1 | Readout request |
| rd_r_i | input | 5 | Readout radial bin |
| rd_z_i | input | 5 | Readout depth bin |
| rd_valid_o | output | 1 | Readout data valid |
| rd_data_o | output | 32 | Cell total |

## Verification
The bench sends streams of packets to a single cell, both back to back and interleaved with a second cell. A design with no bypass, or with a bypass keyed on the wrong address, would drop or double count updates, and the totals read back would differ from the bench's model. Saturation is forced with weights close to full scale and a fraction near one. A design that wraps would read back a small number instead of all ones. The bench also covers positions past the grid edge and exactly on the last bin, a layer index out of range, a readout that collides with a packet, and packets sent during a clear. These expose a missing clamp, an off-by-one clamp, a wrong layer fallback, a stale read reported as valid, and a grid changed by packets that should have been dropped.

// File: rtl/absorb_score_pkg.sv
package absorb_score_pkg;
  localparam int unsigned ACC_W = 32;
  typedef logic [ACC_W-1:0] acc_t;

  function automatic acc_t sat_add(input acc_t a, input acc_t b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction
endpackage

// File: rtl/absorb_bin_map.sv
module absorb_bin_map #(
  parameter int unsigned POS_W   = 16,
  parameter int unsigned SHIFT_W = 5,
  parameter int unsigned BINS    = 32,
  parameter int unsigned IDX_W   = $clog2(BINS)
) (
  input  logic [POS_W-1:0]   pos_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [POS_W-1:0] scaled;

  always_comb begin
    scaled = pos_i >> shift_i;
    if (scaled > POS_W'(BINS - 1)) idx_o = IDX_W'(BINS - 1);
    else                           idx_o = scaled[IDX_W-1:0];
  end
endmodule

// File: rtl/absorb_weight_drop.sv
module absorb_weight_drop #(
  parameter int unsigned W_W      = 32,
  parameter int unsigned RATIO_W  = 16,
  parameter int unsigned N_LAYERS = 5,
  parameter int unsigned LAYER_W  = $clog2(N_LAYERS),
  parameter int unsigned ADDR_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [LAYER_W-1:0] cfg_layer_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic               in_valid_i,
  input  logic [W_W-1:0]     weight_i,
  input  logic [LAYER_W-1:0] layer_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               out_valid_o,
  output logic [W_W-1:0]     out_weight_o,
  output logic [W_W-1:0]     abs_o,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned PROD_W = W_W + RATIO_W;

  logic [RATIO_W-1:0] ratio_q [N_LAYERS];
  logic [RATIO_W-1:0] ratio_sel;
  logic [PROD_W-1:0]  prod;
  logic [W_W-1:0]     absorbed;

  for (genvar l = 0; l < N_LAYERS; l++) begin : g_layer
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ratio_q[l] <= '0;
      else if (cfg_we_i && int'(cfg_layer_i) == l)    ratio_q[l] <= cfg_ratio_i;
    end
  end

  always_comb begin
    // out-of-range layer falls back to the deepest layer
    if (int'(layer_i) >= N_LAYERS) ratio_sel = ratio_q[N_LAYERS-1];
    else                           ratio_sel = ratio_q[layer_i];
    prod     = PROD_W'(weight_i) * PROD_W'(ratio_sel);
    absorbed = W_W'(prod >> RATIO_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_weight_o <= '0;
      abs_o        <= '0;
      addr_o       <= '0;
    end else begin
      out_valid_o  <= in_valid_i;
      out_weight_o <= weight_i - absorbed;
      abs_o        <= absorbed;
      addr_o       <= addr_i;
    end
  end

  p_weight_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (out_weight_o <= $past(weight_i)));
endmodule

// File: rtl/absorb_grid.sv
module absorb_grid
  import absorb_score_pkg::*;
#(
  parameter int unsigned N_CELLS = 1024,
  parameter int unsigned ADDR_W  = $clog2(N_CELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  acc_t              upd_amt_i,
  input  logic              clr_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output acc_t              rd_data_o
);
  acc_t              mem [N_CELLS];
  acc_t              mem_rd_q;
  logic [ADDR_W-1:0] rd_sel;

  logic              s2_valid_q;
  logic [ADDR_W-1:0] s2_addr_q;
  acc_t              s2_amt_q;
  logic              fwd_valid_q;
  logic [ADDR_W-1:0] fwd_addr_q;
  acc_t              fwd_data_q;
  logic              busy_q, rd_valid_q;
  logic [ADDR_W-1:0] clr_cnt_q;

  acc_t              operand, sum, wr_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;

  always_comb begin
    rd_sel  = upd_valid_i ? upd_addr_i : rd_addr_i;
    // write issued last cycle is not yet visible in mem_rd_q
    operand = (fwd_valid_q && fwd_addr_q == s2_addr_q) ? fwd_data_q : mem_rd_q;
    sum     = sat_add(operand, s2_amt_q);
    wr_en   = busy_q || s2_valid_q;
    wr_addr = busy_q ? clr_cnt_q : s2_addr_q;
    wr_data = busy_q ? '0 : sum;
  end

  always_ff @(posedge clk_i) begin
    mem_rd_q <= mem[rd_sel];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid_q  <= 1'b0;
      s2_addr_q   <= '0;
      s2_amt_q    <= '0;
      fwd_valid_q <= 1'b0;
      fwd_addr_q  <= '0;
      fwd_data_q  <= '0;
      busy_q      <= 1'b0;
      clr_cnt_q   <= '0;
      rd_valid_q  <= 1'b0;
    end else begin
      s2_valid_q  <= upd_valid_i;
      s2_addr_q   <= upd_addr_i;
      s2_amt_q    <= upd_amt_i;
      fwd_valid_q <= s2_valid_q && !busy_q;
      fwd_addr_q  <= s2_addr_q;
      fwd_data_q  <= sum;
      rd_valid_q  <= rd_en_i && !upd_valid_i && !busy_q;
      if (!busy_q && clr_i) begin
        busy_q    <= 1'b1;
        clr_cnt_q <= '0;
      end else if (busy_q) begin
        clr_cnt_q <= clr_cnt_q + 1'b1;
        if (clr_cnt_q == ADDR_W'(N_CELLS - 1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = mem_rd_q;

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_valid_q && !busy_q) |-> (sum >= operand));
  p_read_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !$past(upd_valid_i));
  p_clear_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(clr_cnt_q) == ADDR_W'(N_CELLS - 1)));
endmodule

// File: rtl/absorb_score.sv
module absorb_score
  import absorb_score_pkg::*;
#(
  parameter int unsigned W_W      = 32,
  parameter int unsigned RATIO_W  = 16,
  parameter int unsigned POS_W    = 16,
  parameter int unsigned N_LAYERS = 5,
  parameter int unsigned R_BINS   = 32,
  parameter int unsigned Z_BINS   = 32,
  localparam int unsigned LAYER_W = $clog2(N_LAYERS),
  localparam int unsigned SHIFT_W = $clog2(POS_W) + 1,
  localparam int unsigned R_IW    = $clog2(R_BINS),
  localparam int unsigned Z_IW    = $clog2(Z_BINS),
  localparam int unsigned N_CELLS = R_BINS * Z_BINS,
  localparam int unsigned ADDR_W  = $clog2(N_CELLS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [LAYER_W-1:0] cfg_layer_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic [SHIFT_W-1:0] dr_shift_i,
  input  logic [SHIFT_W-1:0] dz_shift_i,
  input  logic               pkt_valid_i,
  input  logic [W_W-1:0]     pkt_weight_i,
  input  logic [LAYER_W-1:0] pkt_layer_i,
  input  logic [POS_W-1:0]   pkt_r_i,
  input  logic [POS_W-1:0]   pkt_z_i,
  output logic               pkt_valid_o,
  output logic [W_W-1:0]     pkt_weight_o,
  input  logic               clr_i,
  output logic               busy_o,
  input  logic               rd_en_i,
  input  logic [R_IW-1:0]    rd_r_i,
  input  logic [Z_IW-1:0]    rd_z_i,
  output logic               rd_valid_o,
  output logic [ACC_W-1:0]   rd_data_o
);
  logic [R_IW-1:0]   r_idx;
  logic [Z_IW-1:0]   z_idx;
  logic [ADDR_W-1:0] pkt_addr, rd_addr, s1_addr;
  logic [W_W-1:0]    s1_abs;
  logic              in_valid;

  absorb_bin_map #(.POS_W(POS_W), .SHIFT_W(SHIFT_W), .BINS(R_BINS), .IDX_W(R_IW)) u_r_map (
    .pos_i(pkt_r_i), .shift_i(dr_shift_i), .idx_o(r_idx));
  absorb_bin_map #(.POS_W(POS_W), .SHIFT_W(SHIFT_W), .BINS(Z_BINS), .IDX_W(Z_IW)) u_z_map (
    .pos_i(pkt_z_i), .shift_i(dz_shift_i), .idx_o(z_idx));

  always_comb begin
    pkt_addr = ADDR_W'(r_idx) * ADDR_W'(Z_BINS) + ADDR_W'(z_idx);
    rd_addr  = ADDR_W'(rd_r_i) * ADDR_W'(Z_BINS) + ADDR_W'(rd_z_i);
    in_valid = pkt_valid_i && !busy_o;
  end

  absorb_weight_drop #(
    .W_W(W_W), .RATIO_W(RATIO_W), .N_LAYERS(N_LAYERS), .LAYER_W(LAYER_W), .ADDR_W(ADDR_W)
  ) u_drop (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_layer_i, .cfg_ratio_i,
    .in_valid_i(in_valid), .weight_i(pkt_weight_i), .layer_i(pkt_layer_i), .addr_i(pkt_addr),
    .out_valid_o(pkt_valid_o), .out_weight_o(pkt_weight_o), .abs_o(s1_abs), .addr_o(s1_addr)
  );

  absorb_grid #(.N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) u_grid (
    .clk_i, .rst_ni,
    .upd_valid_i(pkt_valid_o), .upd_addr_i(s1_addr), .upd_amt_i(ACC_W'(s1_abs)),
    .clr_i, .rd_en_i, .rd_addr_i(rd_addr),
    .busy_o, .rd_valid_o, .rd_data_o
  );

  p_drop_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !pkt_valid_o);
  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !busy_o) |=> pkt_valid_o);
endmodule

// File: tb/absorb_score_tb_top.sv
`timescale 1ns/1ps
module absorb_score_tb_top;
  localparam int NB = 32;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 0;
  logic [2:0]  cfg_layer_i = 0;
  logic [15:0] cfg_ratio_i = 0;
  logic [4:0]  dr_shift_i = 0, dz_shift_i = 0;
  logic        pkt_valid_i = 0;
  logic [31:0] pkt_weight_i = 0;
  logic [2:0]  pkt_layer_i = 0;
  logic [15:0] pkt_r_i = 0, pkt_z_i = 0;
  logic        pkt_valid_o;
  logic [31:0] pkt_weight_o;
  logic        clr_i = 0, busy_o;
  logic        rd_en_i = 0;
  logic [4:0]  rd_r_i = 0, rd_z_i = 0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;

  absorb_score dut_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_layer_i, .cfg_ratio_i, .dr_shift_i, .dz_shift_i,
    .pkt_valid_i, .pkt_weight_i, .pkt_layer_i, .pkt_r_i, .pkt_z_i,
    .pkt_valid_o, .pkt_weight_o, .clr_i, .busy_o,
    .rd_en_i, .rd_r_i, .rd_z_i, .rd_valid_o, .rd_data_o);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;
  longint unsigned ratio_m [5];
  longint unsigned model [NB*NB];
  int dr_m = 0, dz_m = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bin_of(input int pos, input int sh);
    int v = pos >> sh;
    return (v > NB - 1) ? NB - 1 : v;
  endfunction

  task automatic set_shift(input int dr, input int dz);
    dr_shift_i = dr[4:0]; dz_shift_i = dz[4:0]; dr_m = dr; dz_m = dz;
  endtask

  task automatic load(input int l, input logic [15:0] ratio);
    cfg_we_i = 1; cfg_layer_i = l[2:0]; cfg_ratio_i = ratio;
    @(negedge clk_i);
    cfg_we_i = 0;
    ratio_m[l] = ratio;
  endtask

  task automatic pkt(input logic [31:0] w, input int l, input int r, input int z, input string req);
    int le = (l >= 5) ? 4 : l;
    longint unsigned wl = w;
    longint unsigned ab = (wl * ratio_m[le]) >> 16;
    longint unsigned rem = wl - ab;
    int a = bin_of(r, dr_m) * NB + bin_of(z, dz_m);
    pkt_valid_i = 1; pkt_weight_i = w; pkt_layer_i = l[2:0];
    pkt_r_i = r[15:0]; pkt_z_i = z[15:0];
    @(negedge clk_i);
    chk(pkt_valid_o === 1'b1 && pkt_weight_o == rem[31:0], req, "out weight",
        {pkt_valid_o, pkt_weight_o}, {1'b1, rem[31:0]});
    pkt_valid_i = 0;
    model[a] = (model[a] + ab > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : model[a] + ab;
  endtask

  task automatic flush();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic rd(input int r, input int z, input string req);
    rd_en_i = 1; rd_r_i = r[4:0]; rd_z_i = z[4:0];
    @(negedge clk_i);
    chk(rd_valid_o === 1'b1, "R8", "rd valid", rd_valid_o, 1);
    chk(rd_data_o == model[r*NB+z][31:0], req, $sformatf("cell %0d,%0d", r, z),
        rd_data_o, model[r*NB+z]);
    rd_en_i = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(!pkt_valid_o && !rd_valid_o && !busy_o, "R10", "in reset",
        {pkt_valid_o, rd_valid_o, busy_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!pkt_valid_o && !rd_valid_o && !busy_o, "R10", "after reset",
        {pkt_valid_o, rd_valid_o, busy_o}, 0);
  endtask

  task automatic t_clear();
    int n = 0;
    clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    while (busy_o && n < 5000) begin n++; @(negedge clk_i); end
    chk(n == NB*NB, "R9", "busy cycles", n, NB*NB);
    for (int i = 0; i < NB*NB; i++) model[i] = 0;
    rd(0, 0, "R9");
    rd(NB-1, NB-1, "R9");
  endtask

  task automatic t_layers();
    load(0, 16'h1000); load(1, 16'h4000); load(2, 16'h8000);
    load(3, 16'hC000); load(4, 16'h0000);
    set_shift(4, 2);
    pkt(32'h1000_0000, 0, 0, 0,  "R1");
    pkt(32'h8765_4321, 1, 0, 4,  "R3");
    pkt(32'h0000_0003, 2, 0, 8,  "R1");
    pkt(32'hFFFF_FFFF, 3, 0, 12, "R3");
    pkt(32'h1234_5678, 4, 0, 16, "R2");
    pkt(32'h0ABC_DEF0, 6, 0, 20, "R3");
    flush();
    rd(0, 0, "R1"); rd(0, 1, "R3"); rd(0, 2, "R1");
    rd(0, 3, "R3"); rd(0, 4, "R2"); rd(0, 5, "R2");
  endtask

  task automatic t_bins();
    set_shift(4, 2);
    pkt(32'h0100_0000, 2, 16'h35, 16'h1B, "R4");
    flush();
    rd(3, 6, "R4");
    set_shift(0, 3);
    pkt(32'h0200_0000, 1, 7, 16'h40, "R4");
    flush();
    rd(7, 8, "R4");
  endtask

  task automatic t_clamp();
    set_shift(4, 3);
    pkt(32'h0040_0000, 2, 16'hFFFF, 16'h1234, "R5");
    set_shift(0, 0);
    pkt(32'h0040_0000, 2, 31, 30, "R5");
    pkt(32'h0040_0000, 2, 32, 31, "R5");
    flush();
    rd(31, 31, "R5"); rd(31, 30, "R5");
  endtask

  task automatic t_stream();
    set_shift(0, 0);
    pkt(32'h100, 2, 10, 10, "R7"); pkt(32'h200, 2, 10, 10, "R7");
    pkt(32'h300, 2, 10, 10, "R7"); pkt(32'h400, 2, 10, 10, "R7");
    pkt(32'h1000, 1, 11, 11, "R7"); pkt(32'h2000, 1, 12, 12, "R7");
    pkt(32'h3000, 1, 11, 11, "R7"); pkt(32'h4000, 1, 12, 12, "R7");
    pkt(32'h5000, 1, 11, 11, "R7");
    flush();
    rd(10, 10, "R7"); rd(11, 11, "R7"); rd(12, 12, "R7");
  endtask

  task automatic t_saturate();
    load(3, 16'hFFFF);
    set_shift(0, 0);
    pkt(32'hFFFF_FFFF, 3, 20, 20, "R6");
    pkt(32'hFFFF_FFFF, 3, 20, 20, "R6");
    pkt(32'hFFFF_FFFF, 3, 20, 20, "R6");
    flush();
    rd(20, 20, "R6");
    chk(model[20*NB+20] == 64'hFFFF_FFFF, "R6", "model saturated", model[20*NB+20], 64'hFFFF_FFFF);
  endtask

  task automatic t_rd_conflict();
    set_shift(0, 0);
    pkt_valid_i = 1; pkt_weight_i = 32'h10; pkt_layer_i = 4; pkt_r_i = 1; pkt_z_i = 1;
    @(negedge clk_i);
    pkt_valid_i = 0;
    rd_en_i = 1; rd_r_i = 0; rd_z_i = 0;
    @(negedge clk_i);
    rd_en_i = 0;
    chk(rd_valid_o === 1'b0, "R8", "rd valid during packet", rd_valid_o, 0);
    flush();
    rd(0, 0, "R8");
  endtask

  task automatic t_busy_drop();
    set_shift(0, 0);
    clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    chk(busy_o === 1'b1, "R9", "busy set", busy_o, 1);
    pkt_valid_i = 1; pkt_weight_i = 32'h8000_0000; pkt_layer_i = 2; pkt_r_i = 5; pkt_z_i = 5;
    @(negedge clk_i);
    pkt_valid_i = 0;
    chk(pkt_valid_o === 1'b0, "R9", "no output while busy", pkt_valid_o, 0);
    while (busy_o) @(negedge clk_i);
    for (int i = 0; i < NB*NB; i++) model[i] = 0;
    rd(5, 5, "R9"); rd(10, 10, "R9");
  endtask

  initial begin
    t_reset();
    t_clear();
    t_layers();
    t_bins();
    t_clamp();
    t_stream();
    t_saturate();
    t_rd_conflict();
    t_busy_drop();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule